// File: doc/BRIEF.md
# Four-Channel Timer Output Compare

This block sits beside a free-running 16-bit up-counting timer and drives four output pins, one per compare channel. Each channel holds a 16-bit compare value. Software loads that value one byte at a time over a small byte-wide register port. Each channel also has a 2-bit action code and one preset bit. The timer count and a one-cycle tick strobe come in as inputs. On every tick where the count equals a channel's compare value, that channel's pin is driven low, driven high or inverted, as its action code selects. The fourth action code ignores matches and holds the pin at the channel's preset bit.

Each channel runs a three-state controller. `CH_FORCED` is entered whenever the action code is 00, and the pin then follows the preset bit. `CH_ARMED` waits for a tick with a matching count. When that tick comes, the channel fires its action and moves to `CH_HELD`. `CH_HELD` suppresses further actions until a tick arrives whose count no longer matches, and then it returns to `CH_ARMED`. While the action code is nonzero, `CH_FORCED` moves to `CH_ARMED` on the next clock. Any state goes to `CH_FORCED` on a clock where the code is 00.

Top module: `oc_unit`

## Requirements
- R1: After reset all four pins are 0, every action code is 00, every preset bit is 0 and every compare byte reads 00h.
- R2: Register map at `bus_addr`: channel n compare low byte at 2n, high byte at 2n+1 (n = 0..3). The action byte is at 8, with channel n in bits [2n+1:2n]. The preset byte is at 9, with channel n in bit n and bits [7:4] always reading 0. Writes take effect at the clock edge where `bus_wr` is high, and `bus_rdata` shows the addressed register combinationally.
- R3: With action code 00 a channel's pin equals its preset bit, one clock after the preset register holds that value. Matches are ignored.
- R4: With action code 01, a tick whose count equals the compare value drives the pin to 0 at that clock edge.
- R5: With action code 10, a matching tick drives the pin to 1 at that clock edge.
- R6: With action code 11, a matching tick inverts the pin at that clock edge.
- R7: With a nonzero action code, a cycle without a tick, or a tick with a non-matching count, leaves the pin unchanged.
- R8: One match gives one action. Further ticks at the same matching count do nothing until a tick with a non-matching count has been seen.
- R9: A match needs all 16 bits to agree: the count must equal {high byte, low byte}, with bit 0 of the low byte as the LSB.
- R10: The channels are independent. Each pin depends only on its own compare value, action code and preset bit.
- R11: A register write and a tick in the same cycle: the tick is judged with the register values held before that write. The new values apply from the next tick on, and the pin does not change at the write edge on account of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tmr_count | input | 16 | Current timer count |
| tmr_tick | input | 1 | High for one cycle when `tmr_count` holds a new value |
| oc_pin | output | 4 | Output-compare pins, bit n for channel n |

## Verification
The risky overlap is a register write landing in the same cycle as a matching tick. The write may change a channel's action code, for example from toggle to preset, or it may move that channel's compare value. Directed steps provoke both cases. They then check that the tick edge acts on the old code or value, and that the new setting shows up only at the following edge. Random stimulus with frequent matches and frequent writes hits this overlap many more times. Every pin is compared against a bench reference model on every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int OC_CW   = 16;
    localparam int OC_BYTE = 8;
    localparam int OC_BPC  = OC_CW / OC_BYTE;

    typedef enum logic [1:0] {
        OCM_INIT = 2'b00,
        OCM_CLR  = 2'b01,
        OCM_SET  = 2'b10,
        OCM_TGL  = 2'b11
    } oc_mode_e;

    typedef enum logic [1:0] {
        CH_FORCED = 2'd0,
        CH_ARMED  = 2'd1,
        CH_HELD   = 2'd2
    } ch_state_e;

endpackage

// File: rtl/oc_cmp.sv
module oc_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;

    always_comb begin
        diff = a ^ b;
        eq   = ~(|diff);
    end
endmodule

// File: rtl/oc_regfile.sv
module oc_regfile
    import oc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [OC_BYTE-1:0]          wdata,
    output logic [OC_BYTE-1:0]          rdata,
    output logic [NCH-1:0][OC_CW-1:0]   cmp_val,
    output logic [2*NCH-1:0]            mode_vec,
    output logic [NCH-1:0]              init_vec
);
    localparam logic [AW-1:0] MODE_ADDR = AW'(OC_BPC * NCH);
    localparam logic [AW-1:0] INIT_ADDR = AW'(OC_BPC * NCH + 1);

    logic [OC_BYTE-1:0] lo_q [NCH];
    logic [OC_BYTE-1:0] hi_q [NCH];
    logic [2*NCH-1:0]   mode_q;
    logic [NCH-1:0]     init_q;

    for (genvar c = 0; c < NCH; c++) begin : g_cmpreg
        localparam logic [AW-1:0] LO_ADDR = AW'(OC_BPC * c);
        localparam logic [AW-1:0] HI_ADDR = AW'(OC_BPC * c + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[c] <= '0;
                hi_q[c] <= '0;
            end else if (wr) begin
                if (addr == LO_ADDR) lo_q[c] <= wdata;
                if (addr == HI_ADDR) hi_q[c] <= wdata;
            end
        end

        assign cmp_val[c] = {hi_q[c], lo_q[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            init_q <= '0;
        end else if (wr) begin
            if (addr == MODE_ADDR) mode_q <= wdata[2*NCH-1:0];
            if (addr == INIT_ADDR) init_q <= wdata[NCH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(OC_BPC * c))     rdata = lo_q[c];
            if (addr == AW'(OC_BPC * c + 1)) rdata = hi_q[c];
        end
        if (addr == MODE_ADDR) rdata = OC_BYTE'(mode_q);
        if (addr == INIT_ADDR) rdata = OC_BYTE'(init_q);
    end

    assign mode_vec = mode_q;
    assign init_vec = init_q;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [OC_CW-1:0] count,
    input  logic [OC_CW-1:0] cmp,
    input  oc_mode_e         mode,
    input  logic             init_bit,
    output logic             pin,
    output logic             fire
);
    logic      hit;
    ch_state_e st_q;
    ch_state_e st_d;

    oc_cmp #(.W(OC_CW)) u_cmp (
        .a  (count),
        .b  (cmp),
        .eq (hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_FORCED;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (mode == OCM_INIT) begin
            st_d = CH_FORCED;
        end else begin
            unique case (st_q)
                CH_FORCED: st_d = CH_ARMED;
                CH_ARMED:  if (tick && hit)  st_d = CH_HELD;
                CH_HELD:   if (tick && !hit) st_d = CH_ARMED;
                default:   st_d = CH_FORCED;
            endcase
        end
    end

    assign fire = (st_q == CH_ARMED) && tick && hit && (mode != OCM_INIT);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            unique case (mode)
                OCM_INIT: pin <= init_bit;
                OCM_CLR:  if (fire) pin <= 1'b0;
                OCM_SET:  if (fire) pin <= 1'b1;
                OCM_TGL:  if (fire) pin <= ~pin;
                default:  pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(OC_BPC * NCH + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic [OC_BYTE-1:0] bus_wdata,
    output logic [OC_BYTE-1:0] bus_rdata,
    input  logic [OC_CW-1:0]   tmr_count,
    input  logic               tmr_tick,
    output logic [NCH-1:0]     oc_pin
);
    logic [NCH-1:0][OC_CW-1:0] cmp_val;
    logic [2*NCH-1:0]          mode_q;
    logic [NCH-1:0]            init_q;
    logic [NCH-1:0]            ch_fire;

    oc_regfile #(.NCH(NCH), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .cmp_val  (cmp_val),
        .mode_vec (mode_q),
        .init_vec (init_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        oc_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tmr_tick),
            .count    (tmr_count),
            .cmp      (cmp_val[c]),
            .mode     (oc_mode_e'(mode_q[2*c +: 2])),
            .init_bit (init_q[c]),
            .pin      (oc_pin[c]),
            .fire     (ch_fire[c])
        );
    end
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_tick,
    input logic [NCH-1:0]   oc_pin,
    input logic [2*NCH-1:0] mode_vec,
    input logic [NCH-1:0]   init_vec,
    input logic [NCH-1:0]   fire_vec
);
    // R1: pins are low on the first edge after reset is seen
    a_r1_reset_pins: assert property (@(posedge clk)
        !rst_n |=> (oc_pin == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: preset code makes the pin follow the preset bit
        a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[2*c +: 2] == 2'b00) |=> (oc_pin[c] == $past(init_vec[c])));

        // R4: clear action
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_vec[c] && mode_vec[2*c +: 2] == 2'b01) |=> !oc_pin[c]);

        // R5: set action
        a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_vec[c] && mode_vec[2*c +: 2] == 2'b10) |=> oc_pin[c]);

        // R6: toggle action
        a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_vec[c] && mode_vec[2*c +: 2] == 2'b11) |=> (oc_pin[c] != $past(oc_pin[c])));

        // R7: no tick means no change outside preset code
        a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmr_tick && mode_vec[2*c +: 2] != 2'b00) |=> $stable(oc_pin[c]));

        // R8: never two actions back to back for one channel
        a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
            fire_vec[c] |=> !fire_vec[c]);
    end
endmodule

bind oc_unit oc_unit_chk #(.NCH(NCH)) u_oc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_tick (tmr_tick),
    .oc_pin   (oc_pin),
    .mode_vec (mode_q),
    .init_vec (init_q),
    .fire_vec (ch_fire)
);

// File: tb/test_oc_unit.sv
`timescale 1ns/1ps
module test_oc_unit;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] tmr_count = '0;
    logic        tmr_tick = 1'b0;
    logic [3:0]  oc_pin;

    int total = 0;
    int bad   = 0;

    oc_unit #(.NCH(NCH)) i_oc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_count (tmr_count),
        .tmr_tick  (tmr_tick),
        .oc_pin    (oc_pin)
    );

    always #4 clk = ~clk;

    // reference model state: 0 forced, 1 armed, 2 held
    logic [7:0] m_lo [NCH];
    logic [7:0] m_hi [NCH];
    logic [1:0] m_mode [NCH];
    logic       m_init [NCH];
    logic       m_pin [NCH];
    int         m_st [NCH];

    function automatic logic [3:0] model_pins();
        logic [3:0] p;
        for (int c = 0; c < NCH; c++) p[c] = m_pin[c];
        return p;
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        logic [7:0] r;
        r = 8'h00;
        if (a < 4'd8) r = a[0] ? m_hi[a[3:1]] : m_lo[a[3:1]];
        else if (a == 4'd8) r = {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
        else if (a == 4'd9) r = {4'h0, m_init[3], m_init[2], m_init[1], m_init[0]};
        return r;
    endfunction

    task automatic model_edge(input bit w, input logic [3:0] a, input logic [7:0] d,
                              input bit t, input logic [15:0] cnt);
        for (int c = 0; c < NCH; c++) begin
            bit hit;
            bit act;
            hit = t && (cnt == {m_hi[c], m_lo[c]});
            act = (m_st[c] == 1) && hit && (m_mode[c] != 2'b00);
            case (m_mode[c])
                2'b00: m_pin[c] = m_init[c];
                2'b01: if (act) m_pin[c] = 1'b0;
                2'b10: if (act) m_pin[c] = 1'b1;
                default: if (act) m_pin[c] = ~m_pin[c];
            endcase
            if (m_mode[c] == 2'b00) m_st[c] = 0;
            else if (m_st[c] == 0) m_st[c] = 1;
            else if (m_st[c] == 1 && hit) m_st[c] = 2;
            else if (m_st[c] == 2 && t && !hit) m_st[c] = 1;
        end
        if (w) begin
            if (a < 4'd8) begin
                if (a[0]) m_hi[a[3:1]] = d;
                else      m_lo[a[3:1]] = d;
            end else if (a == 4'd8) begin
                for (int c = 0; c < NCH; c++) m_mode[c] = d[2*c +: 2];
            end else if (a == 4'd9) begin
                for (int c = 0; c < NCH; c++) m_init[c] = d[c];
            end
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_lo[c] = 8'h00; m_hi[c] = 8'h00; m_mode[c] = 2'b00;
            m_init[c] = 1'b0; m_pin[c] = 1'b0; m_st[c] = 0;
        end
    endtask

    // one clock: drive at negedge, model at posedge, return at next negedge
    task automatic cyc(input bit w, input logic [3:0] a, input logic [7:0] d,
                       input bit t, input logic [15:0] cnt);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        tmr_tick = t; tmr_count = cnt;
        @(posedge clk);
        model_edge(w, a, d, t, cnt);
        @(negedge clk);
        bus_wr = 1'b0; tmr_tick = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C5EED11));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pins", {4'h0, oc_pin}, 8'h00);
        for (int a = 0; a < 10; a++) check_reg("R1 reg", 4'(a), 8'h00);

        // R2: register map readback
        for (int a = 0; a < 8; a++) cyc(1'b1, 4'(a), 8'(8'h11 * (a + 1)), 1'b0, 16'h0);
        for (int a = 0; a < 8; a++) check_reg("R2 cmp byte", 4'(a), 8'(8'h11 * (a + 1)));
        cyc(1'b1, 4'd9, 8'hFF, 1'b0, 16'h0);
        check_reg("R2 preset upper zero", 4'd9, 8'h0F);

        // compare values: ch0 1234, ch1 0100, ch2 0200, ch3 0300
        cyc(1'b1, 4'd0, 8'h34, 1'b0, 16'h0); cyc(1'b1, 4'd1, 8'h12, 1'b0, 16'h0);
        cyc(1'b1, 4'd2, 8'h00, 1'b0, 16'h0); cyc(1'b1, 4'd3, 8'h01, 1'b0, 16'h0);
        cyc(1'b1, 4'd4, 8'h00, 1'b0, 16'h0); cyc(1'b1, 4'd5, 8'h02, 1'b0, 16'h0);
        cyc(1'b1, 4'd6, 8'h00, 1'b0, 16'h0); cyc(1'b1, 4'd7, 8'h03, 1'b0, 16'h0);

        // R3: preset code
        cyc(1'b1, 4'd9, 8'h05, 1'b0, 16'h0);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h1234);
        check("R3 preset 0101", {4'h0, oc_pin}, 8'h05);
        cyc(1'b1, 4'd9, 8'h02, 1'b0, 16'h0);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 16'h0);
        check("R3 preset 0010", {4'h0, oc_pin}, 8'h02);

        // codes: ch0 set, ch1 clear, ch2 toggle, ch3 set
        cyc(1'b1, 4'd8, 8'hB6, 1'b0, 16'h0);
        check_reg("R2 action byte", 4'd8, 8'hB6);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 16'h0);
        check("R7 code change hold", {4'h0, oc_pin}, 8'h02);

        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h1234);
        check("R5 set", {4'h0, oc_pin}, 8'h03);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0034);
        check("R9 low byte only", {4'h0, oc_pin}, 8'h03);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h1200);
        check("R9 high byte only", {4'h0, oc_pin}, 8'h03);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0100);
        check("R4 clear", {4'h0, oc_pin}, 8'h01);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 16'h0200);
        check("R7 no tick", {4'h0, oc_pin}, 8'h01);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0200);
        check("R6 toggle up", {4'h0, oc_pin}, 8'h05);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0200);
        check("R8 held match", {4'h0, oc_pin}, 8'h05);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0201);
        check("R7 mismatch tick", {4'h0, oc_pin}, 8'h05);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0200);
        check("R8 rearmed toggle", {4'h0, oc_pin}, 8'h01);

        // R11: compare write then ticks
        cyc(1'b1, 4'd6, 8'h10, 1'b0, 16'h0);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0300);
        check("R11 old compare dead", {4'h0, oc_pin}, 8'h01);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0310);
        check("R11 new compare live", {4'h0, oc_pin}, 8'h09);

        // R11: action-byte write in the same cycle as a match
        cyc(1'b1, 4'd8, 8'h36, 1'b1, 16'h0200);
        check("R11 old code at write edge", {4'h0, oc_pin}, 8'h0D);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 16'h0);
        check("R11 new code next edge", {4'h0, oc_pin}, 8'h05);

        // R11: compare write in the same cycle as a tick at the new value
        cyc(1'b1, 4'd4, 8'h55, 1'b1, 16'h0255);
        check("R11 tick uses old compare", {4'h0, oc_pin}, 8'h05);
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 16'h0255);
        check("R11 tick uses new compare", {4'h0, oc_pin}, 8'h01);

        // R10: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit          w;
            bit          t;
            logic [3:0]  a;
            logic [7:0]  d;
            logic [15:0] cnt;
            int          ch;
            w = ($urandom % 5) == 0;
            a = 4'($urandom % 10);
            d = 8'($urandom);
            t = ($urandom % 10) < 6;
            ch = int'($urandom % NCH);
            case ($urandom % 4)
                0, 1:    cnt = {m_hi[ch], m_lo[ch]};
                2:       cnt = {m_hi[ch], m_lo[ch]} + 16'd1;
                default: cnt = 16'($urandom % 8);
            endcase
            if (($urandom % 6) == 0) begin
                a = 4'(2 * ch + ($urandom % 2));
                d = 8'($urandom % 4);
                w = 1'b1;
            end
            cyc(w, a, d, t, cnt);
            check("R10 pins vs model", {4'h0, oc_pin}, {4'h0, model_pins()});
            if ((i % 97) == 0) begin
                logic [3:0] ra;
                ra = 4'($urandom % 10);
                check_reg("R2 random readback", ra, model_read(ra));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule